// File: doc/BRIEF.md
# Resampler Timing Oscillator

This block is the timing oscillator that paces a sample-rate resampler. A 32-bit phase accumulator advances by an increment made of a center frequency word and an optional offset word. It produces a one-cycle carry strobe and the top five accumulator bits, which the resampling filter uses as its advance strobe and its fractional phase index.

Static control inputs select the mode. In frequency mode the accumulator integrates, so the output sample rate changes. In phase mode the accumulator feedback is disabled, so the top bits of the increment act as a fixed phase offset and the carry is forced. The center frequency can be loaded at once or held pending until a sync pulse. The increment is refreshed either at the start of a filter instruction or at the last tap of each output. The accumulator feedback can be zeroed when a new center frequency is loaded, which aligns several channels to a common phase, or it can be held at zero by a test control. The offset word arrives serially, and its length is set by a 2-bit size code.

Top module: `rs_timing_nco`

## Requirements
- R1: While reset is asserted, and after reset, `phase_o` is 0 and `carry_o` is 0 until an increment has been loaded.
- R2: With `mode_freq`=1 and no clear condition, each clock adds the active increment to the accumulator modulo 2^32. `phase_o` shows accumulator bits [31:27]. `carry_o` is high for exactly the cycle after an addition that wrapped past 2^32.
- R3: With `mode_freq`=0 the accumulator feedback is disabled, so each clock loads the accumulator with the increment alone and `phase_o` equals increment bits [31:27].
- R4: `force_carry` is ORed with the natural carry. `carry_o` is high in the cycle after any clock at which `force_carry` was 1.
- R5: While `hold_fb` is 1 the accumulator feedback is zero, so the accumulator takes the increment alone.
- R6: With `clr_on_load`=1, the feedback is zeroed in the same clock at which the active center frequency is loaded.
- R7: With `sync_en`=0, a `cfreq_wr` loads `cfreq_in` into the active center frequency directly. With `sync_en`=1, `cfreq_wr` only writes a pending register, and the pending value moves to the active register on a `sync_in` pulse.
- R8: The increment register reloads only on an update tick. The tick is `instr_start` when `upd_at_start`=1 and `last_tap` when `upd_at_start`=0. Between ticks the increment register holds its value.
- R9: The serial offset is shifted in MSB first, one bit per clock while `ser_en` is 1. `ser_sync` marks the first bit. After 8*(size+1) bits, where `ofs_size` is 00=8, 01=16, 10=24 and 11=32 bits, the word is committed left-aligned into 32 bits. Bits after the commit and before the next `ser_sync` are ignored.
- R10: When `ofs_en` is 0 at an update tick, the offset contributes zero to the new increment.
- R11: At an update tick the new increment is the active center frequency plus the committed offset, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_freq | input | 1 | 1 selects frequency shift, 0 selects phase shift |
| force_carry | input | 1 | Forces the carry strobe high |
| clr_on_load | input | 1 | Zeroes the feedback when the active center frequency loads |
| hold_fb | input | 1 | Holds the accumulator feedback at zero |
| upd_at_start | input | 1 | Selects the update tick: 1 = `instr_start`, 0 = `last_tap` |
| sync_en | input | 1 | Routes center frequency loads through the pending register and `sync_in` |
| ofs_en | input | 1 | Enables the offset contribution |
| ofs_size | input | 2 | Serial word length code |
| cfreq_in | input | 32 | Center frequency word |
| cfreq_wr | input | 1 | Center frequency write strobe |
| sync_in | input | 1 | Sync pulse |
| instr_start | input | 1 | Start-of-instruction strobe |
| last_tap | input | 1 | Last-tap-of-output strobe |
| ser_data | input | 1 | Serial offset data bit |
| ser_en | input | 1 | Serial bit enable |
| ser_sync | input | 1 | Marks the first bit of a serial word |
| carry_o | output | 1 | Carry strobe |
| phase_o | output | 5 | Fractional phase index |

## Verification
The in-line assertions watch the behaviours that hold on every cycle:
- phase mode and the hold control load the accumulator with the increment alone;
- a forced carry always appears on the next cycle;
- the increment register stays stable between ticks;
- the active center frequency stays stable while waiting for a sync;
- the serial bit counter never goes past the longest word.

The bench scenarios cover the behaviours that span many cycles:
- wrap timing and carry spacing for several increments;
- the choice of update tick;
- serial words of each length being assembled, aligned and added;
- the offset enable;
- bits that arrive after a commit being ignored;
- the feedback clear at a load.

// File: rtl/rsnco_pkg.sv
package rsnco_pkg;
  localparam int ACC_W   = 32;
  localparam int PHASE_W = 5;
  localparam int CNT_W   = $clog2(ACC_W + 1);

  // serial word length code
  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_24 = 2'b10,
    SZ_32 = 2'b11
  } ser_size_e;

  function automatic logic [CNT_W-1:0] size_bits(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    n = CNT_W'(({1'b0, code} + 3'd1) * 4'd8);
    return n;
  endfunction
endpackage

// File: rtl/rsnco_rst_sync.sv
module rsnco_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/rsnco_ser_loader.sv
module rsnco_ser_loader
  import rsnco_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         ser_en_i,
  input  logic         ser_sync_i,
  input  logic         ser_data_i,
  input  logic [1:0]   size_i,
  output logic [W-1:0] ofs_word_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg_q, shreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [W-1:0]  ofs_q, ofs_d;
  logic [W-1:0]  shifted;
  logic [CW-1:0] nbits;
  logic [7:0]    shamt;

  assign nbits   = CW'(size_bits(size_i));
  assign shamt   = 8'(W) - 8'(nbits);
  assign shifted = {shreg_q[W-2:0], ser_data_i};

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    ofs_d   = ofs_q;
    if (ser_en_i) begin
      if (ser_sync_i) begin
        shreg_d = {{(W-1){1'b0}}, ser_data_i};
        cnt_d   = CW'(1);
        busy_d  = 1'b1;
      end else if (busy_q) begin
        shreg_d = shifted;
        cnt_d   = cnt_q + CW'(1);
        if (cnt_q + CW'(1) == nbits) begin
          ofs_d  = shifted << shamt;
          busy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      ofs_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      ofs_q   <= ofs_d;
    end
  end

  assign ofs_word_o = ofs_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(W)) else $error("serial count exceeds word"); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ser_en_i) |=> $stable(ofs_q)) else $error("offset changed without serial enable"); // R9
endmodule

// File: rtl/rsnco_freq_regs.sv
module rsnco_freq_regs
  import rsnco_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] cfreq_i,
  input  logic         cfreq_wr_i,
  input  logic         sync_en_i,
  input  logic         sync_i,
  input  logic         upd_start_i,
  input  logic         instr_start_i,
  input  logic         last_tap_i,
  input  logic         ofs_en_i,
  input  logic [W-1:0] ofs_word_i,
  output logic [W-1:0] inc_o,
  output logic         cf_load_o
);
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] act_q, act_d;
  logic [W-1:0] inc_q, inc_d;
  logic         load_ev;
  logic         tick;
  logic [W-1:0] ofs_term;

  assign load_ev  = sync_en_i ? sync_i : cfreq_wr_i;
  assign tick     = upd_start_i ? instr_start_i : last_tap_i;
  assign ofs_term = ofs_en_i ? ofs_word_i : '0;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    inc_d  = inc_q;
    if (cfreq_wr_i) pend_d = cfreq_i;
    if (load_ev)    act_d  = sync_en_i ? pend_q : cfreq_i;
    if (tick)       inc_d  = act_q + ofs_term;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      inc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      inc_q  <= inc_d;
    end
  end

  assign inc_o     = inc_q;
  assign cf_load_o = load_ev;

  AST_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!(upd_start_i ? instr_start_i : last_tap_i)) |=> $stable(inc_q)) else $error("increment moved off tick"); // R8

  AST_WAIT_SYNC: assert property (@(posedge clk) disable iff (!rst_ni)
    (sync_en_i && !sync_i) |=> $stable(act_q)) else $error("active frequency moved without sync"); // R7
endmodule

// File: rtl/rsnco_phase_acc.sv
module rsnco_phase_acc
  import rsnco_pkg::*;
#(
  parameter int W  = ACC_W,
  parameter int PW = PHASE_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          mode_freq_i,
  input  logic          hold_fb_i,
  input  logic          clr_on_load_i,
  input  logic          cf_load_i,
  input  logic          force_carry_i,
  input  logic [W-1:0]  inc_i,
  output logic [PW-1:0] phase_o,
  output logic          carry_o
);
  logic [W-1:0] acc_q, acc_d;
  logic         carry_q, carry_d;
  logic         fb_zero;
  logic [W-1:0] feedback;
  logic [W:0]   sum;

  assign fb_zero  = hold_fb_i | ~mode_freq_i | (clr_on_load_i & cf_load_i);
  assign feedback = fb_zero ? '0 : acc_q;
  assign sum      = {1'b0, feedback} + {1'b0, inc_i};

  always_comb begin
    acc_d   = sum[W-1:0];
    carry_d = sum[W] | force_carry_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  assign phase_o = acc_q[W-1 -: PW];
  assign carry_o = carry_q;

  AST_PHASE_NO_FB: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_freq_i) |=> (acc_q == $past(inc_i))) else $error("phase mode kept feedback"); // R3

  AST_FORCED_CARRY: assert property (@(posedge clk) disable iff (!rst_ni)
    force_carry_i |=> carry_q) else $error("forced carry missing"); // R4

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_fb_i |=> (acc_q == $past(inc_i))) else $error("hold did not zero feedback"); // R5

  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_on_load_i && cf_load_i) |=> (acc_q == $past(inc_i))) else $error("load clear failed"); // R6
endmodule

// File: rtl/rs_timing_nco.sv
module rs_timing_nco
  import rsnco_pkg::*;
#(
  parameter int W  = ACC_W,
  parameter int PW = PHASE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_freq,
  input  logic          force_carry,
  input  logic          clr_on_load,
  input  logic          hold_fb,
  input  logic          upd_at_start,
  input  logic          sync_en,
  input  logic          ofs_en,
  input  logic [1:0]    ofs_size,
  input  logic [W-1:0]  cfreq_in,
  input  logic          cfreq_wr,
  input  logic          sync_in,
  input  logic          instr_start,
  input  logic          last_tap,
  input  logic          ser_data,
  input  logic          ser_en,
  input  logic          ser_sync,
  output logic          carry_o,
  output logic [PW-1:0] phase_o
);
  logic         rst_s_n;
  logic [W-1:0] ofs_word;
  logic [W-1:0] inc;
  logic         cf_load;

  rsnco_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_s_n)
  );

  rsnco_ser_loader #(.W(W)) u_ser (
    .clk        (clk),
    .rst_ni     (rst_s_n),
    .ser_en_i   (ser_en),
    .ser_sync_i (ser_sync),
    .ser_data_i (ser_data),
    .size_i     (ofs_size),
    .ofs_word_o (ofs_word)
  );

  rsnco_freq_regs #(.W(W)) u_freq (
    .clk           (clk),
    .rst_ni        (rst_s_n),
    .cfreq_i       (cfreq_in),
    .cfreq_wr_i    (cfreq_wr),
    .sync_en_i     (sync_en),
    .sync_i        (sync_in),
    .upd_start_i   (upd_at_start),
    .instr_start_i (instr_start),
    .last_tap_i    (last_tap),
    .ofs_en_i      (ofs_en),
    .ofs_word_i    (ofs_word),
    .inc_o         (inc),
    .cf_load_o     (cf_load)
  );

  rsnco_phase_acc #(.W(W), .PW(PW)) u_acc (
    .clk           (clk),
    .rst_ni        (rst_s_n),
    .mode_freq_i   (mode_freq),
    .hold_fb_i     (hold_fb),
    .clr_on_load_i (clr_on_load),
    .cf_load_i     (cf_load),
    .force_carry_i (force_carry),
    .inc_i         (inc),
    .phase_o       (phase_o),
    .carry_o       (carry_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (!carry_o && phase_o == '0)) else $error("outputs not clear after reset"); // R1
endmodule

// File: tb/rs_timing_nco_bench.sv
`timescale 1ns/1ps
module rs_timing_nco_bench;
  logic        clk;
  logic        rst_n;
  logic        mode_freq, force_carry, clr_on_load, hold_fb, upd_at_start;
  logic        sync_en, ofs_en;
  logic [1:0]  ofs_size;
  logic [31:0] cfreq_in;
  logic        cfreq_wr, sync_in, instr_start, last_tap;
  logic        ser_data, ser_en, ser_sync;
  logic        carry_o;
  logic [4:0]  phase_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // reference model state
  logic [31:0] m_pend, m_act, m_inc, m_acc, m_ofs, m_sh;
  logic        m_carry, m_busy;
  int          m_cnt;
  string       cur_tag;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  rs_timing_nco u_rs_timing_nco (
    .clk(clk), .rst_n(rst_n), .mode_freq(mode_freq), .force_carry(force_carry),
    .clr_on_load(clr_on_load), .hold_fb(hold_fb), .upd_at_start(upd_at_start),
    .sync_en(sync_en), .ofs_en(ofs_en), .ofs_size(ofs_size), .cfreq_in(cfreq_in),
    .cfreq_wr(cfreq_wr), .sync_in(sync_in), .instr_start(instr_start),
    .last_tap(last_tap), .ser_data(ser_data), .ser_en(ser_en), .ser_sync(ser_sync),
    .carry_o(carry_o), .phase_o(phase_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of one clock edge, following the requirements
  task automatic model_edge();
    logic        load, tick, clr;
    logic [32:0] sum;
    logic [31:0] n_act, n_pend, n_inc, shn;
    int          nbits;
    nbits  = 8 * (int'(ofs_size) + 1);
    load   = sync_en ? sync_in : cfreq_wr;
    n_act  = load ? (sync_en ? m_pend : cfreq_in) : m_act;
    n_pend = cfreq_wr ? cfreq_in : m_pend;
    tick   = upd_at_start ? instr_start : last_tap;
    n_inc  = tick ? (m_act + (ofs_en ? m_ofs : 32'h0)) : m_inc;
    clr    = hold_fb | ~mode_freq | (clr_on_load & load);
    sum    = {1'b0, (clr ? 32'h0 : m_acc)} + {1'b0, m_inc};
    if (ser_en) begin
      if (ser_sync) begin
        m_sh = {31'h0, ser_data}; m_cnt = 1; m_busy = 1;
      end else if (m_busy) begin
        shn = {m_sh[30:0], ser_data};
        m_sh = shn; m_cnt = m_cnt + 1;
        if (m_cnt == nbits) begin
          m_ofs = shn << (32 - nbits); m_busy = 0;
        end
      end
    end
    m_acc = sum[31:0]; m_carry = sum[32] | force_carry;
    m_act = n_act; m_pend = n_pend; m_inc = n_inc;
  endtask

  // driver: one clock, push expected outputs
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      exp_q.push_back({m_carry, m_acc[31:27]});
      tag_q.push_back(cur_tag);
      @(negedge clk);
    end
  endtask

  // monitor: compare DUT against the scoreboard
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " carry/phase"}, {26'h0, carry_o, phase_o}, {26'h0, e});
    end
  end

  task automatic pulse_wr(logic [31:0] v);
    cfreq_in = v; cfreq_wr = 1; step(1); cfreq_wr = 0;
  endtask
  task automatic pulse_start(); instr_start = 1; step(1); instr_start = 0; endtask
  task automatic pulse_last();  last_tap = 1; step(1); last_tap = 0; endtask
  task automatic pulse_sync();  sync_in = 1; step(1); sync_in = 0; endtask

  task automatic send(logic [31:0] v, int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_en = 1; ser_sync = (i == 0); ser_data = v[nbits-1-i];
      step(1);
    end
    ser_en = 0; ser_sync = 0; ser_data = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    {mode_freq, force_carry, clr_on_load, hold_fb, upd_at_start, sync_en, ofs_en} = '0;
    ofs_size = 0; cfreq_in = 0; cfreq_wr = 0; sync_in = 0; instr_start = 0; last_tap = 0;
    ser_data = 0; ser_en = 0; ser_sync = 0;
    m_pend = 0; m_act = 0; m_inc = 0; m_acc = 0; m_ofs = 0; m_sh = 0;
    m_carry = 0; m_busy = 0; m_cnt = 0; cur_tag = "R1";
    repeat (5) @(negedge clk);
    check("R1 phase in reset", {27'h0, phase_o}, 32'h0);
    check("R1 carry in reset", {31'h0, carry_o}, 32'h0);
    rst_n = 1;
    step(6);

    // R2 R7 R8 R11 frequency mode, direct load, start-of-instruction update
    cur_tag = "R2"; mode_freq = 1; upd_at_start = 1;
    pulse_wr(32'h1000_0000);
    pulse_start();
    step(40);

    // R8 per-output update: instr_start must be ignored
    cur_tag = "R8"; upd_at_start = 0;
    pulse_wr(32'h2345_6789);
    pulse_start();
    step(5);
    pulse_last();
    step(30);

    // R9 R11 serial offsets of each length
    cur_tag = "R9"; ofs_en = 1; ofs_size = 2'b00;
    send(32'hA5, 8);
    pulse_last(); step(20);
    ser_en = 1; ser_data = 1; step(5); ser_en = 0; ser_data = 0;
    pulse_last(); step(10);
    cur_tag = "R11"; ofs_size = 2'b10;
    send(32'hC35AF0, 24);
    pulse_last(); step(20);
    ofs_size = 2'b11;
    send(32'h8000_0001, 32);
    pulse_last(); step(20);
    ofs_size = 2'b01;
    send(32'h7FF1, 16);
    pulse_last(); step(20);

    // R10 offset disabled
    cur_tag = "R10"; ofs_en = 0;
    pulse_last(); step(20);

    // R7 sync-gated load
    cur_tag = "R7"; sync_en = 1;
    pulse_wr(32'h0800_0000);
    step(5); pulse_last(); step(5);
    pulse_sync(); pulse_last(); step(20);

    // R6 feedback cleared on load
    cur_tag = "R6"; clr_on_load = 1;
    pulse_wr(32'h0400_0000);
    step(3); pulse_sync(); step(20);
    clr_on_load = 0;

    // R5 hold feedback
    cur_tag = "R5"; hold_fb = 1; step(6); hold_fb = 0; step(10);

    // R3 R4 phase mode with forced carry and an 8-bit offset
    cur_tag = "R3"; mode_freq = 0; force_carry = 1;
    pulse_wr(32'h0); pulse_sync();
    ofs_en = 1; ofs_size = 2'b00;
    send(32'hA5, 8);
    pulse_last(); step(2);
    check("R9 aligned offset phase", {27'h0, phase_o}, 32'h14);
    check("R4 forced carry", {31'h0, carry_o}, 32'h1);
    step(5);
    cur_tag = "R4"; mode_freq = 1; force_carry = 0; step(30);

    step(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule